// File: doc/BRIEF.md
# Three-Port Parallel I/O with Single-Bit Set/Clear

This block gives a processor three 8-bit parallel ports, named A, B and C, plus one control register. All four are reached through a two-bit address. Each port line has an output latch, a live input path and a drive enable. The drive enable lets the pad logic put the pin into the high-impedance state when the line is an input. Port C is split into an upper and a lower nibble, and each nibble has its own direction.

The control address accepts two kinds of word, and bit 7 tells them apart. A configuration word sets the direction of each port group and clears every output latch. A single-bit command edits one bit of the port C latch in place. Software therefore never has to read the port, modify the bit and write it back. Written data stays in the latches after the bus cycle ends. Reads of input lines return the pin value at that moment, with no storage.

Top module: `pio_triport`

## Requirements
- R1: While reset is applied and after it is released, every drive enable is 0 and every output latch is 0. Reading the control address (3) then returns 8'h9B, which means all groups are inputs.
- R2: A write to address 0, 1 or 2 loads the write data into the latch of port A, B or C, and only that latch. This happens whatever the direction of the port.
- R3: A write to address 3 with bit 7 = 1 is a configuration word, with 1 = input and 0 = output. Bit 4 sets port A, bit 1 sets port B, bit 3 sets the upper nibble of port C and bit 0 sets the lower nibble. A group set to output drives all of its lines (enable 1). The enables change only on such a write.
- R4: A configuration word clears all three output latches to 0 on the same clock edge.
- R5: With no write, all latches hold their value from cycle to cycle.
- R6: A read of a port returns the live pin value for each line in an input group and the latch value for each line in an output group. For port C this is decided per nibble.
- R7: A write to address 3 with bit 7 = 0 is a single-bit command. Bits 3..1 give the port C bit index (0 to 7) and bit 0 gives the new value. Only that bit of the port C latch changes, and ports A and B are untouched.
- R8: A single-bit command does not change the drive enables or the word read back from address 3. That word stays the last configuration word.
- R9: A single-bit command updates the port C latch even when the addressed nibble is an input. The new value shows on the port C latch output while its enable stays 0.
- R10: While the read strobe is low, the read data bus is 0. Reading address 3 returns the stored configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | 0 = port A, 1 = port B, 2 = port C, 3 = control |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, combinational read data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pa_pin_i | input | 8 | Port A pin levels |
| pa_drv_o | output | 8 | Port A output latch |
| pa_oe_o | output | 8 | Port A drive enables |
| pb_pin_i | input | 8 | Port B pin levels |
| pb_drv_o | output | 8 | Port B output latch |
| pb_oe_o | output | 8 | Port B drive enables |
| pc_pin_i | input | 8 | Port C pin levels |
| pc_drv_o | output | 8 | Port C output latch |
| pc_oe_o | output | 8 | Port C drive enables |

## Verification
The properties assume that the bus strobes and address are stable for the whole clock period around each sampling edge. They also assume that write and read are not asserted together. The bench changes every input only on the falling edge and never raises both strobes at once. The live-read properties take the pin inputs as free-running values that the design must pass through, so the bench changes the pins between reads to show that nothing is stored.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PORT_W = 8;
  localparam int HALF_W = PORT_W / 2;
  localparam int IDX_W  = $clog2(PORT_W);
  localparam logic [PORT_W-1:0] CTRL_RESET = 8'h9B;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  // 1 = group is input
  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cu_in;
    logic cl_in;
  } dir_t;

  function automatic logic is_config(input logic [PORT_W-1:0] w);
    return w[7];
  endfunction

  function automatic dir_t dir_of(input logic [PORT_W-1:0] w);
    dir_t d;
    d.a_in  = w[4];
    d.b_in  = w[1];
    d.cu_in = w[3];
    d.cl_in = w[0];
    return d;
  endfunction

  function automatic logic [IDX_W-1:0] bit_index(input logic [PORT_W-1:0] w);
    return w[IDX_W:1];
  endfunction

  // per-line pick between pin and latch
  function automatic logic [PORT_W-1:0] merge(input logic [PORT_W-1:0] pin,
                                              input logic [PORT_W-1:0] lat,
                                              input logic [PORT_W-1:0] in_mask);
    return (pin & in_mask) | (lat & ~in_mask);
  endfunction
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] ctrl_q,
  output dir_t              dir,
  output logic              mode_wr,
  output logic              bsr_wr,
  output logic [IDX_W-1:0]  bsr_idx,
  output logic              bsr_val,
  output logic [2:0]        port_wr
);
  logic ctrl_sel;

  assign ctrl_sel = wr && (sel_e'(addr) == SEL_CTRL);
  assign mode_wr  = ctrl_sel && is_config(wdata);
  assign bsr_wr   = ctrl_sel && !is_config(wdata);
  assign bsr_idx  = bit_index(wdata);
  assign bsr_val  = wdata[0];

  always_comb begin
    port_wr = '0;
    if (wr) begin
      unique case (sel_e'(addr))
        SEL_A:    port_wr[0] = 1'b1;
        SEL_B:    port_wr[1] = 1'b1;
        SEL_C:    port_wr[2] = 1'b1;
        default:  port_wr    = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RESET;
    else if (mode_wr) ctrl_q <= wdata;
  end

  assign dir = dir_of(ctrl_q);
endmodule

// File: rtl/pio_latch.sv
module pio_latch
  import pio_pkg::*;
#(
  parameter int W        = PORT_W,
  parameter bit BIT_EDIT = 1'b0,
  localparam int IW      = $clog2(W)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic [W-1:0]  d,
  input  logic          bit_wr,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  output logic [W-1:0]  q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   q <= '0;
    else if (clr)                 q <= '0;
    else if (ld)                  q <= d;
    else if (BIT_EDIT && bit_wr)  q[bit_idx] <= bit_val;
  end
endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
  import pio_pkg::*;
(
  input  logic              rd,
  input  logic [1:0]        addr,
  input  dir_t              dir,
  input  logic [PORT_W-1:0] ctrl_q,
  input  logic [PORT_W-1:0] lat_a,
  input  logic [PORT_W-1:0] lat_b,
  input  logic [PORT_W-1:0] lat_c,
  input  logic [PORT_W-1:0] pin_a,
  input  logic [PORT_W-1:0] pin_b,
  input  logic [PORT_W-1:0] pin_c,
  output logic [PORT_W-1:0] rdata
);
  logic [PORT_W-1:0] mask_a, mask_b, mask_c;

  assign mask_a = {PORT_W{dir.a_in}};
  assign mask_b = {PORT_W{dir.b_in}};
  assign mask_c = {{HALF_W{dir.cu_in}}, {HALF_W{dir.cl_in}}};

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (sel_e'(addr))
        SEL_A:    rdata = merge(pin_a, lat_a, mask_a);
        SEL_B:    rdata = merge(pin_b, lat_b, mask_b);
        SEL_C:    rdata = merge(pin_c, lat_c, mask_c);
        default:  rdata = ctrl_q;
      endcase
    end
  end
endmodule

// File: rtl/pio_triport.sv
module pio_triport
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pa_pin_i,
  output logic [PORT_W-1:0] pa_drv_o,
  output logic [PORT_W-1:0] pa_oe_o,
  input  logic [PORT_W-1:0] pb_pin_i,
  output logic [PORT_W-1:0] pb_drv_o,
  output logic [PORT_W-1:0] pb_oe_o,
  input  logic [PORT_W-1:0] pc_pin_i,
  output logic [PORT_W-1:0] pc_drv_o,
  output logic [PORT_W-1:0] pc_oe_o
);
  localparam int NPORT = 3;

  logic [PORT_W-1:0] ctrl_q;
  dir_t              dir;
  logic              mode_wr, bsr_wr, bsr_val, any_wr;
  logic [IDX_W-1:0]  bsr_idx;
  logic [NPORT-1:0]  port_wr;
  logic [PORT_W-1:0] lat [NPORT];

  pio_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .dir(dir), .mode_wr(mode_wr), .bsr_wr(bsr_wr),
    .bsr_idx(bsr_idx), .bsr_val(bsr_val), .port_wr(port_wr)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_lat
    pio_latch #(.W(PORT_W), .BIT_EDIT(p == 2)) u_lat (
      .clk(clk), .rst_n(rst_n), .clr(mode_wr), .ld(port_wr[p]), .d(bus_wdata),
      .bit_wr(bsr_wr), .bit_idx(bsr_idx), .bit_val(bsr_val), .q(lat[p])
    );
  end

  pio_rdmux u_rd (
    .rd(bus_rd), .addr(bus_addr), .dir(dir), .ctrl_q(ctrl_q),
    .lat_a(lat[0]), .lat_b(lat[1]), .lat_c(lat[2]),
    .pin_a(pa_pin_i), .pin_b(pb_pin_i), .pin_c(pc_pin_i), .rdata(bus_rdata)
  );

  assign any_wr   = bus_wr;
  assign pa_drv_o = lat[0];
  assign pb_drv_o = lat[1];
  assign pc_drv_o = lat[2];
  assign pa_oe_o  = {PORT_W{!dir.a_in}};
  assign pb_oe_o  = {PORT_W{!dir.b_in}};
  assign pc_oe_o  = {{HALF_W{!dir.cu_in}}, {HALF_W{!dir.cl_in}}};
endmodule

// File: rtl/pio_triport_chk.sv
module pio_triport_chk
  import pio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_addr,
  input logic              bus_rd,
  input logic [PORT_W-1:0] bus_rdata,
  input logic [PORT_W-1:0] pa_pin_i,
  input logic [PORT_W-1:0] pc_pin_i,
  input logic [PORT_W-1:0] pa_drv_o,
  input logic [PORT_W-1:0] pb_drv_o,
  input logic [PORT_W-1:0] pc_drv_o,
  input logic [PORT_W-1:0] pa_oe_o,
  input logic [PORT_W-1:0] pb_oe_o,
  input logic [PORT_W-1:0] pc_oe_o,
  input logic              mode_wr,
  input logic              bsr_wr,
  input logic              any_wr
);
  p_oe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pc_oe_o));

  p_nibble_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_oe_o[HALF_W-1:0] == '0 || pc_oe_o[HALF_W-1:0] == '1) &&
    (pc_oe_o[PORT_W-1:HALF_W] == '0 || pc_oe_o[PORT_W-1:HALF_W] == '1));

  p_mode_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> pa_drv_o == '0 && pb_drv_o == '0 && pc_drv_o == '0);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> $stable(pa_drv_o) && $stable(pb_drv_o) && $stable(pc_drv_o));

  p_live_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 2'd0 && pa_oe_o == '0 |-> bus_rdata == pa_pin_i);

  p_live_cl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 2'd2 && pc_oe_o[0] == 1'b0 |->
    bus_rdata[HALF_W-1:0] == pc_pin_i[HALF_W-1:0]);

  p_bsr_onebit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_wr |=> $countones(pc_drv_o ^ $past(pc_drv_o)) <= 1 &&
               $stable(pa_drv_o) && $stable(pb_drv_o));

  p_bsr_keeps_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_wr |=> $stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pc_oe_o));

  p_idle_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);
endmodule

bind pio_triport pio_triport_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .pa_pin_i(pa_pin_i), .pc_pin_i(pc_pin_i),
  .pa_drv_o(pa_drv_o), .pb_drv_o(pb_drv_o), .pc_drv_o(pc_drv_o),
  .pa_oe_o(pa_oe_o), .pb_oe_o(pb_oe_o), .pc_oe_o(pc_oe_o),
  .mode_wr(mode_wr), .bsr_wr(bsr_wr), .any_wr(any_wr)
);

// File: tb/test_pio_triport.sv
module test_pio_triport;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pa_pin_i = '0, pb_pin_i = '0, pc_pin_i = '0;
  logic [7:0] pa_drv_o, pb_drv_o, pc_drv_o, pa_oe_o, pb_oe_o, pc_oe_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_ctrl = 8'h9B;

  always #2 clk = ~clk;

  pio_triport i_pio_triport (.*);

  // {addr, wdata, exp A latch, exp B latch, exp C latch, out flags {A,B,CU,CL}}
  localparam logic [37:0] VEC [12] = '{
    {2'd3, 8'h80, 8'h00, 8'h00, 8'h00, 4'hF},
    {2'd0, 8'h5A, 8'h5A, 8'h00, 8'h00, 4'hF},
    {2'd1, 8'hC3, 8'h5A, 8'hC3, 8'h00, 4'hF},
    {2'd2, 8'h0F, 8'h5A, 8'hC3, 8'h0F, 4'hF},
    {2'd3, 8'h0F, 8'h5A, 8'hC3, 8'h8F, 4'hF},
    {2'd3, 8'h00, 8'h5A, 8'hC3, 8'h8E, 4'hF},
    {2'd3, 8'h0B, 8'h5A, 8'hC3, 8'hAE, 4'hF},
    {2'd3, 8'h91, 8'h00, 8'h00, 8'h00, 4'h6},
    {2'd0, 8'h33, 8'h33, 8'h00, 8'h00, 4'h6},
    {2'd3, 8'h03, 8'h33, 8'h00, 8'h02, 4'h6},
    {2'd1, 8'hFF, 8'h33, 8'hFF, 8'h02, 4'h6},
    {2'd3, 8'h88, 8'h00, 8'h00, 8'h00, 4'hD}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 2'd3 && d[7]) exp_ctrl = d;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic check_idle_state(input string tag);
    logic [7:0] r;
    chk({pa_oe_o, pb_oe_o, pc_oe_o} == '0, tag, {pa_oe_o, pb_oe_o, pc_oe_o}, 0);
    chk({pa_drv_o, pb_drv_o, pc_drv_o} == '0, tag, {pa_drv_o, pb_drv_o, pc_drv_o}, 0);
    bus_read(2'd3, r);
    chk(r == 8'h9B, tag, r, 8'h9B);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, snap_a, snap_b, snap_c;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk({pa_oe_o, pb_oe_o, pc_oe_o} == '0, "R1 oe in reset", {pa_oe_o, pb_oe_o, pc_oe_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle_state("R1 after reset");

    // vector table: R2 R3 R4 R7 R9
    for (int i = 0; i < 12; i++) begin
      logic [37:0] v;
      logic [3:0]  f;
      logic [23:0] exp_oe;
      v = VEC[i];
      f = v[3:0];
      bus_write(v[37:36], v[35:28]);
      chk({pa_drv_o, pb_drv_o, pc_drv_o} == v[27:4],
          "R2/R4/R7/R9 latches", {pa_drv_o, pb_drv_o, pc_drv_o}, v[27:4]);
      exp_oe = {{8{f[3]}}, {8{f[2]}}, {4{f[1]}}, {4{f[0]}}};
      chk({pa_oe_o, pb_oe_o, pc_oe_o} == exp_oe, "R3/R8 enables",
          {pa_oe_o, pb_oe_o, pc_oe_o}, exp_oe);
      bus_read(2'd3, r);
      chk(r == exp_ctrl, "R8/R10 control readback", r, exp_ctrl);
    end

    // R5: hold without writes
    snap_a = pa_drv_o; snap_b = pb_drv_o; snap_c = pc_drv_o;
    bus_write(2'd0, 8'h11);
    bus_write(2'd2, 8'hE7);
    snap_a = pa_drv_o; snap_b = pb_drv_o; snap_c = pc_drv_o;
    repeat (6) @(negedge clk);
    chk({pa_drv_o, pb_drv_o, pc_drv_o} == {snap_a, snap_b, snap_c}, "R5 hold",
        {pa_drv_o, pb_drv_o, pc_drv_o}, {snap_a, snap_b, snap_c});
    chk(snap_a == 8'h11 && snap_c == 8'hE7, "R2 data write", {snap_a, snap_c}, 16'h11E7);

    // R6: live reads, mode A in, B out, C upper out, C lower in
    bus_write(2'd3, 8'h91);
    pa_pin_i = 8'hA5;
    bus_read(2'd0, r);
    chk(r == 8'hA5, "R6 live A", r, 8'hA5);
    pa_pin_i = 8'h3C;
    bus_read(2'd0, r);
    chk(r == 8'h3C, "R6 live A changed", r, 8'h3C);
    bus_write(2'd1, 8'h6E);
    pb_pin_i = 8'h00;
    bus_read(2'd1, r);
    chk(r == 8'h6E, "R6 output B reads latch", r, 8'h6E);
    bus_write(2'd2, 8'h5C);
    pc_pin_i = 8'hA3;
    bus_read(2'd2, r);
    chk(r == 8'h53, "R6 C nibble mix", r, 8'h53);

    // R7/R8: index 6 cleared, control word and enables unchanged
    bus_write(2'd3, 8'h0C);
    chk(pc_drv_o == 8'h1C, "R7 bit 6 clear", pc_drv_o, 8'h1C);
    chk(pc_oe_o == 8'hF0, "R8 enables kept", pc_oe_o, 8'hF0);
    bus_read(2'd3, r);
    chk(r == 8'h91, "R8 control kept", r, 8'h91);
    // R9: lower nibble is input, bit 0 set still lands in latch
    bus_write(2'd3, 8'h01);
    chk(pc_drv_o == 8'h1D && pc_oe_o[0] == 1'b0, "R9 input-half edit",
        {pc_oe_o, pc_drv_o}, 16'hF01D);

    // R10: read strobe low
    @(negedge clk);
    bus_addr = 2'd3;
    #1 chk(bus_rdata == 8'h00, "R10 idle read bus", bus_rdata, 0);

    // R1: reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle_state("R1 second reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule